// File: doc/BRIEF.md
# Decimal-Capable Byte Add/Subtract Unit

This block is the arithmetic core of an 8-bit accumulator datapath. It adds with carry or subtracts with borrow, and it works either in plain two's-complement binary or in packed BCD, two decimal digits per byte. It takes the accumulator byte, an operand byte, the incoming carry, a decimal-mode select and an add/subtract select. It returns the result byte and four flags: negative, zero, carry and overflow.

The unit is registered. When `start` is high at a rising clock edge, the inputs are sampled and the result and flags are loaded. During the cycle that follows, `done` is high for exactly one cycle. While `start` is low the outputs hold their last values, and changes on the inputs have no effect.

Decimal mode follows the lenient behaviour of early 8-bit processors:
- Digits that are not valid BCD are corrected, not rejected.
- The zero and overflow flags always come from the plain binary sum.
- In a decimal add, the negative flag comes from the sum after the low-digit fix but before the high-digit fix.

Top module: `alu_dec8`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, `result` is 0x00, all four flags are 0 and `done` is 0.
- R2: `start` sampled high at a clock edge makes `done` high during the next cycle only; `start` sampled low makes `done` low.
- R3: Binary add (op_sub=0, dec_mode=0): result = (acc + opnd + carry_in) mod 256, and C is the carry out of bit 7 (0x80+0x80 gives 0x00 with C=1, Z=1, N=0).
- R4: Subtract (op_sub=1) uses carry as an inverted borrow: the binary result = acc + ~opnd + carry_in, and C=1 exactly when acc + carry_in > opnd. This holds in both modes (0x00-0x01 with carry set gives 0xFF, C=0, N=1).
- R5: Z is 1 exactly when the binary result (R3/R4 form) is 0x00, in both modes (decimal 0x99+0x01 gives 0x00 with Z=0).
- R6: N is bit 7 of the binary result, except in a decimal add, where it is bit 7 of the sum after the low-digit correction and before the high-digit correction.
- R7: V is 1 when both addends of the binary sum (opnd inverted for subtract) have equal sign bits and the binary result's sign differs. This holds in both modes.
- R8: Decimal add: when the low digit sum (acc[3:0]+opnd[3:0]+carry_in) exceeds 9, 6 is added to it and a carry of 1 goes to the high digit. This includes non-BCD digits: 0x0A+0x01 gives 0x11.
- R9: Decimal add: when the high digit sum, including the low-digit carry, exceeds 9, 6 is added to that digit and C=1; otherwise C=0. With BCD inputs, every result digit is 0..9 (0x10+0x89 gives 0x99 with C=0, N=1).
- R10: Decimal subtract: a digit whose difference goes negative is corrected by subtracting 6 and borrows from the next digit. C is taken from the binary subtraction (0x00-0x01 with carry set gives 0x99, C=0).
- R11: When `start` is low, changes on acc_in, opnd_in, carry_in, dec_mode and op_sub leave result and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Sample the inputs and load the result at this edge |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed BCD arithmetic |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry in (inverted borrow when subtracting) |
| result | output | 8 | Registered result byte |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The bench targets the three decimal quirks:
- A zero flag taken from the corrected result would report Z=1 for 0x99+0x01.
- A negative flag taken from the final result would miss N=1 for that same add.
- A design that rejected non-BCD digits would not return 0x11 for 0x0A+0x01.

Subtraction is exercised where a borrow ripples through both digits, such as 0x00-0x01 in decimal. A design with an uninverted borrow sense, or with C taken from the adjusted value, shows a wrong result or carry there. Idle cycles with toggling inputs expose a register that reloads without `start`. A long random run compares every cycle against a behavioural model, which catches slips in the overflow signs and the carry chain.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned NIB = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } alu_op_e;

endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu_bin_core.sv
module alu_bin_core #(
  parameter int unsigned W = 8
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_bcd_digit.sv
module alu_bcd_digit
  import alu_pkg::*;
(
  input  logic           sub,
  input  logic [NIB-1:0] a,
  input  logic [NIB-1:0] b,
  input  logic           ci,      // carry (add) or borrow (sub)
  output logic [NIB-1:0] d,
  output logic           co,      // carry (add) or borrow (sub)
  output logic           raw_msb  // top bit of the uncorrected add digit
);
  logic [NIB:0]   s_add;
  logic [NIB+1:0] s_sub;
  logic           fix;

  always_comb begin
    s_add   = {1'b0, a} + {1'b0, b} + {{NIB{1'b0}}, ci};
    s_sub   = {2'b00, a} - {2'b00, b} - {{(NIB+1){1'b0}}, ci};
    raw_msb = s_add[NIB-1];
    if (sub) begin
      fix = s_sub[NIB+1];
      d   = fix ? (s_sub[NIB-1:0] - 4'd6) : s_sub[NIB-1:0];
    end else begin
      fix = (s_add > 5'd9);
      d   = fix ? (s_add[NIB-1:0] + 4'd6) : s_add[NIB-1:0];
    end
    co = fix;
  end
endmodule

// File: rtl/alu_dec8.sv
module alu_dec8
  import alu_pkg::*;
#(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned W = DIGITS * NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_sub,
  input  logic         dec_mode,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         done
);
  logic         srst_n;
  logic [W-1:0] bin_sum;
  logic         bin_cout;
  logic         bin_ovf;
  logic [DIGITS:0]   dchain;
  logic [DIGITS-1:0] raw_top;
  logic [W-1:0] dec_sum;

  alu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  alu_bin_core #(.W(W)) i_bin (
    .sub  (op_sub),
    .a    (acc_in),
    .b    (opnd_in),
    .cin  (carry_in),
    .sum  (bin_sum),
    .cout (bin_cout),
    .ovf  (bin_ovf)
  );

  // add: carry enters directly; sub: carry is an inverted borrow
  assign dchain[0] = op_sub ? ~carry_in : carry_in;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    alu_bcd_digit i_dig (
      .sub     (op_sub),
      .a       (acc_in[g*NIB +: NIB]),
      .b       (opnd_in[g*NIB +: NIB]),
      .ci      (dchain[g]),
      .d       (dec_sum[g*NIB +: NIB]),
      .co      (dchain[g+1]),
      .raw_msb (raw_top[g])
    );
  end

  // next-state logic
  logic [W-1:0] res_d, res_q;
  alu_flags_t   flg_d, flg_q;
  logic         done_d, done_q;

  always_comb begin
    res_d  = res_q;
    flg_d  = flg_q;
    done_d = start;
    if (start) begin
      flg_d.z = (bin_sum == '0);
      flg_d.v = bin_ovf;
      if (dec_mode) begin
        res_d   = dec_sum;
        flg_d.n = op_sub ? bin_sum[W-1] : raw_top[DIGITS-1];
        flg_d.c = op_sub ? bin_cout : dchain[DIGITS];
      end else begin
        res_d   = bin_sum;
        flg_d.n = bin_sum[W-1];
        flg_d.c = bin_cout;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign flag_n = flg_q.n;
  assign flag_z = flg_q.z;
  assign flag_c = flg_q.c;
  assign flag_v = flg_q.v;
  assign done   = done_q;

  // assertions
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!srst_n)
    !start |=> !done);
  a_r11_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !start |=> ($stable(result) && $stable(flag_n) && $stable(flag_z)
                && $stable(flag_c) && $stable(flag_v)));
  a_r4_sub_carry: assert property (@(posedge clk) disable iff (!srst_n)
    (start && op_sub) |=>
      (flag_c == (({1'b0, $past(acc_in)} + {{W{1'b0}}, $past(carry_in)})
                  > {1'b0, $past(opnd_in)})));
  a_r9_bcd_digits: assert property (@(posedge clk) disable iff (!srst_n)
    (start && dec_mode && !op_sub && acc_in[3:0] <= 4'd9 && acc_in[7:4] <= 4'd9
     && opnd_in[3:0] <= 4'd9 && opnd_in[7:4] <= 4'd9) |=>
      (result[3:0] <= 4'd9 && result[7:4] <= 4'd9));
  a_r3_bin_add: assert property (@(posedge clk) disable iff (!srst_n)
    (start && !dec_mode && !op_sub) |=>
      ({flag_c, result} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}
                            + {{W{1'b0}}, $past(carry_in)})));
endmodule

// File: tb/test_alu_dec8.sv
module test_alu_dec8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_sub = 1'b0, dec_mode = 1'b0, carry_in = 1'b0;
  logic [7:0] acc_in = 8'h00, opnd_in = 8'h00;
  logic [7:0] result;
  logic flag_n, flag_z, flag_c, flag_v, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alu_dec8 i_alu_dec8 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
    .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in),
    .carry_in(carry_in), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .done(done));

  // behavioural reference state
  int e_res = 0, e_n = 0, e_z = 0, e_c = 0, e_v = 0, e_done = 0;

  task automatic ref_op(input int a, input int b, input int c,
                        input int dec, input int sub);
    int bin, al, t;
    bin = sub ? (a + (255 - b) + c) : (a + b + c);
    e_z = ((bin & 255) == 0);
    if (sub) e_v = (((a ^ b) & (a ^ bin) & 128) != 0);
    else     e_v = ((~(a ^ b) & (a ^ bin) & 128) != 0);
    if (!dec) begin
      e_res = bin & 255; e_n = (bin >> 7) & 1; e_c = (bin > 255);
    end else if (!sub) begin
      al = (a & 15) + (b & 15) + c;
      if (al >= 10) al = ((al + 6) & 15) + 16;
      t = (a & 240) + (b & 240) + al;
      e_n = (t >> 7) & 1;
      if (t >= 160) t = t + 96;
      e_c = (t >= 256);
      e_res = t & 255;
    end else begin
      al = (a & 15) - (b & 15) + c - 1;
      if (al < 0) al = ((al - 6) & 15) - 16;
      t = (a & 240) - (b & 240) + al;
      if (t < 0) t = t - 96;
      e_res = t & 255;
      e_n = (bin >> 7) & 1;
      e_c = (bin > 255);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "result", int'(result), e_res);
    chk(req, "N", int'(flag_n), e_n);
    chk(req, "Z", int'(flag_z), e_z);
    chk(req, "C", int'(flag_c), e_c);
    chk(req, "V", int'(flag_v), e_v);
    chk("R2", "done", int'(done), e_done);
  endtask

  // one operation, then one idle cycle with scrambled inputs (R11)
  task automatic run_op(input string req, input int a, input int b, input int c,
                        input int dec, input int sub);
    acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = c[0];
    dec_mode = dec[0]; op_sub = sub[0]; start = 1'b1;
    ref_op(a, b, c, dec, sub); e_done = 1;
    @(negedge clk);
    chk_all(req);
    start = 1'b0;
    acc_in = ~acc_in; opnd_in = opnd_in + 8'h35; carry_in = ~carry_in;
    dec_mode = ~dec_mode; op_sub = ~op_sub; e_done = 0;
    @(negedge clk);
    chk_all("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1");

    // binary add: R3, R5, R6, R7
    run_op("R3", 8'h00, 8'h01, 0, 0, 0);
    run_op("R6", 8'h01, 8'h7F, 0, 0, 0);
    run_op("R7", 8'h01, 8'h7F, 0, 0, 0);
    run_op("R5", 8'h80, 8'h80, 0, 0, 0);
    run_op("R3", 8'hFF, 8'h00, 1, 0, 0);
    // binary subtract: R4
    run_op("R4", 8'h01, 8'h01, 1, 0, 1);
    run_op("R4", 8'h00, 8'h01, 1, 0, 1);
    run_op("R7", 8'h80, 8'h01, 1, 0, 1);
    run_op("R4", 8'h05, 8'h05, 0, 0, 1);
    // decimal add: R8, R9, R5, R6
    run_op("R8", 8'h01, 8'h09, 0, 1, 0);
    run_op("R9", 8'h10, 8'h89, 0, 1, 0);
    run_op("R5", 8'h99, 8'h01, 0, 1, 0);
    run_op("R6", 8'h99, 8'h01, 0, 1, 0);
    run_op("R8", 8'h0A, 8'h01, 0, 1, 0);
    run_op("R9", 8'h58, 8'h46, 1, 1, 0);
    run_op("R7", 8'h79, 8'h01, 0, 1, 0);
    // decimal subtract: R10
    run_op("R10", 8'h00, 8'h01, 1, 1, 1);
    run_op("R10", 8'h32, 8'h15, 1, 1, 1);
    run_op("R10", 8'h10, 8'h01, 1, 1, 1);
    run_op("R10", 8'h50, 8'h25, 0, 1, 1);

    // back-to-back starts (R2) then random sweep compared every cycle
    for (int i = 0; i < 600; i++) begin
      int a, b, c, d, s;
      a = $urandom_range(0, 255); b = $urandom_range(0, 255);
      c = $urandom_range(0, 1); d = $urandom_range(0, 1); s = $urandom_range(0, 1);
      if ($urandom_range(0, 3) != 0) begin
        acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = c[0];
        dec_mode = d[0]; op_sub = s[0]; start = 1'b1;
        ref_op(a, b, c, d, s); e_done = 1;
      end else begin
        start = 1'b0; acc_in = a[7:0]; opnd_in = b[7:0]; e_done = 0;
      end
      @(negedge clk);
      chk_all(d ? (s ? "R10" : "R9") : (s ? "R4" : "R3"));
    end
    start = 1'b0;
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not complete");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule